// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches 32 asynchronous external event lines and turns selected edges on them into a level interrupt for a parent interrupt controller and into single-cycle event pulses. Each line has its own enable for rising edges and its own enable for falling edges. A line with both enabled fires on either edge. Detected rising edges and detected falling edges are latched in two separate pending registers. Software reads these registers to find the source and clears a line by writing a one to its bit.

Software programs the block through a simple register port made of an address, write data, a write strobe and combinational read data. Besides the two trigger enables there is an interrupt mask, which gates pending bits onto the interrupt output, and an event mask, which gates detected edges onto the event pulse output. A write-only software trigger register lets a handler re-raise an event on a line as if a real edge had arrived, for example to replay an interrupt that was lost.

Top module: `edge_irq_hub`

## Requirements
- R1: After reset every readable register reads 0, and irq_o and evt_o are low.
- R2: The rising-enable (offset 0x00), falling-enable (0x04), interrupt-mask (0x80) and event-mask (0x84) registers read back exactly what was last written. Bit n of each register belongs to line n.
- R3: A rising edge on a line whose rising-enable bit is set sets bit n of the rising pending register (0x0C). The bit is set on the third rising clock edge after the input changes. Holding the line high afterwards never sets the bit again.
- R4: A falling edge on a line whose falling-enable bit is set sets bit n of the falling pending register (0x10). A rising edge on a line with only its falling enable set has no effect.
- R5: A line with both enable bits set latches its rising edge into the rising pending register and its falling edge into the falling pending register.
- R6: An edge on a line that has no enable for that edge direction changes neither pending register and produces no event pulse.
- R7: Writing a one to a pending bit clears it on that clock edge. Writing a zero leaves it unchanged.
- R8: If an edge sets a pending bit on the same clock edge as a write-one clear of that bit, the bit stays set.
- R9: Writing a one to bit n of the software trigger register (0x08) sets rising pending bit n on that write's clock edge, whatever the trigger enables hold. The register always reads as 0.
- R10: irq_o is high while any bit of (rising pending OR falling pending) AND interrupt mask is set, and low otherwise.
- R11: evt_o is high for exactly one cycle, starting on the clock edge that sets a pending bit, when the line with that edge or software trigger has its event-mask bit set. It stays low for lines whose event-mask bit is clear.
- R12: Reads of any address not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 32 | Asynchronous external event lines |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level-high interrupt to the parent controller |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
Faults in the synchroniser or in the previous-value flop show up as a pending bit that appears one cycle early or late, or as a bit that comes back after being cleared while the line is held. The bench reads the pending register in the first cycle the bit can appear, so these faults are visible at once. A wrong clear priority appears as a zero read right after a clear that collides with an edge. Masking faults show up on irq_o and evt_o in the same or the next cycle, because both are checked right after each mask write and each edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int unsigned NUM_LINES = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = NUM_LINES;

    localparam logic [ADDR_W-1:0] OFF_RISE_EN   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_FALL_EN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SW_TRIG   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_RISE_PEND = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_FALL_PEND = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_IRQ_MASK  = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_EVT_MASK  = 8'h84;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RISE_EN,
        SEL_FALL_EN,
        SEL_SW_TRIG,
        SEL_RISE_PEND,
        SEL_FALL_PEND,
        SEL_IRQ_MASK,
        SEL_EVT_MASK
    } reg_sel_e;

    // Per-line configuration held by the register file.
    typedef struct packed {
        line_vec_t rise_en;
        line_vec_t fall_en;
        line_vec_t irq_mask;
        line_vec_t evt_mask;
    } cfg_t;

    // One vector per edge direction: used for detected edges, sets, clears and pending state.
    typedef struct packed {
        line_vec_t rise;
        line_vec_t fall;
    } edge_pair_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_RISE_EN:   s = SEL_RISE_EN;
            OFF_FALL_EN:   s = SEL_FALL_EN;
            OFF_SW_TRIG:   s = SEL_SW_TRIG;
            OFF_RISE_PEND: s = SEL_RISE_PEND;
            OFF_FALL_PEND: s = SEL_FALL_PEND;
            OFF_IRQ_MASK:  s = SEL_IRQ_MASK;
            OFF_EVT_MASK:  s = SEL_EVT_MASK;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync
    import edge_irq_pkg::*;
#(
    parameter int unsigned LINES  = NUM_LINES,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] shreg;
        logic              prev_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                shreg  <= '0;
                prev_q <= 1'b0;
            end else begin
                shreg  <= {shreg[STAGES-2:0], line_i[i]};
                prev_q <= shreg[STAGES-1];
            end
        end

        assign rise_o[i] =  shreg[STAGES-1] & ~prev_q;
        assign fall_o[i] = ~shreg[STAGES-1] &  prev_q;
    end

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  edge_pair_t        pend_i,
    output cfg_t              cfg_o,
    output line_vec_t         sw_trig_o,
    output edge_pair_t        clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    reg_sel_e sel;
    cfg_t     cfg_q;

    assign sel = decode_addr(addr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else if (we_i) begin
            case (sel)
                SEL_RISE_EN:  cfg_q.rise_en  <= wdata_i;
                SEL_FALL_EN:  cfg_q.fall_en  <= wdata_i;
                SEL_IRQ_MASK: cfg_q.irq_mask <= wdata_i;
                SEL_EVT_MASK: cfg_q.evt_mask <= wdata_i;
                default: ;
            endcase
        end
    end

    // Pulse-type write outputs: software trigger and write-one clears.
    always_comb begin
        sw_trig_o = '0;
        clr_o     = '0;
        if (we_i) begin
            case (sel)
                SEL_SW_TRIG:   sw_trig_o  = wdata_i;
                SEL_RISE_PEND: clr_o.rise = wdata_i;
                SEL_FALL_PEND: clr_o.fall = wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_RISE_EN:   rdata_o = cfg_q.rise_en;
            SEL_FALL_EN:   rdata_o = cfg_q.fall_en;
            SEL_RISE_PEND: rdata_o = pend_i.rise;
            SEL_FALL_PEND: rdata_o = pend_i.fall;
            SEL_IRQ_MASK:  rdata_o = cfg_q.irq_mask;
            SEL_EVT_MASK:  rdata_o = cfg_q.evt_mask;
            default:       rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/edge_irq_pend.sv
module edge_irq_pend
    import edge_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  edge_pair_t set_i,
    input  edge_pair_t clr_i,
    output edge_pair_t pend_o
);

    edge_pair_t pend_q;

    // A set on the same edge as a clear wins.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
        end else begin
            pend_q.rise <= (pend_q.rise & ~clr_i.rise) | set_i.rise;
            pend_q.fall <= (pend_q.fall & ~clr_i.fall) | set_i.fall;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub
    import edge_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o,
    output logic                 evt_o
);

    edge_pair_t raw_edge;
    edge_pair_t set_vec;
    edge_pair_t clr_vec;
    edge_pair_t pend;
    cfg_t       cfg;
    line_vec_t  sw_trig;
    logic       evt_q;

    // Signals exposed for the bound checker.
    line_vec_t  pend_rise;
    line_vec_t  pend_fall;
    line_vec_t  rise_set;
    line_vec_t  irq_mask;

    edge_irq_sync #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .line_i (line_i),
        .rise_o (raw_edge.rise),
        .fall_o (raw_edge.fall)
    );

    edge_irq_regs u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .pend_i    (pend),
        .cfg_o     (cfg),
        .sw_trig_o (sw_trig),
        .clr_o     (clr_vec),
        .rdata_o   (rdata_o)
    );

    // Qualify edges by direction enable; software trigger acts as a rising edge.
    always_comb begin
        set_vec.rise = (raw_edge.rise & cfg.rise_en) | sw_trig;
        set_vec.fall =  raw_edge.fall & cfg.fall_en;
    end

    edge_irq_pend u_pend (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= |((set_vec.rise | set_vec.fall) & cfg.evt_mask);
        end
    end

    assign irq_o     = |((pend.rise | pend.fall) & cfg.irq_mask);
    assign evt_o     = evt_q;
    assign pend_rise = pend.rise;
    assign pend_fall = pend.fall;
    assign rise_set  = set_vec.rise;
    assign irq_mask  = cfg.irq_mask;

endmodule

// File: rtl/edge_irq_hub_chk.sv
module edge_irq_hub_chk
    import edge_irq_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input line_vec_t         pend_rise,
    input line_vec_t         pend_fall,
    input line_vec_t         rise_set,
    input line_vec_t         irq_mask
);

    a_r9_swtrig_reads_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == OFF_SW_TRIG) |-> (rdata_o == '0));

    a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (decode_addr(addr_i) == SEL_NONE) |-> (rdata_o == '0));

    a_r2_mask_readback: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == OFF_IRQ_MASK) |=> (irq_mask == $past(wdata_i)));

    a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == OFF_RISE_PEND) |=>
        ((pend_rise & $past(wdata_i) & ~$past(rise_set)) == '0));

    a_r7_pend_kept_without_write: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> (((pend_rise & $past(pend_rise)) == $past(pend_rise)) &&
                   ((pend_fall & $past(pend_fall)) == $past(pend_fall))));

    a_r10_irq_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !we_i) |=> irq_o);

    a_r10_no_pend_no_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_rise == '0 && pend_fall == '0) |-> !irq_o);

endmodule

bind edge_irq_hub edge_irq_hub_chk chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .pend_rise (pend_rise),
    .pend_fall (pend_fall),
    .rise_set  (rise_set),
    .irq_mask  (irq_mask)
);

// File: tb/edge_irq_hub_tb.sv
module edge_irq_hub_tb_top;
    import edge_irq_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef enum logic [1:0] {K_REG, K_IRQ, K_EVT} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_i = 1'b1;
    logic [31:0]       line_i = '0;
    logic              we_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              irq_o;
    logic              evt_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_hub dut_i (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .line_i  (line_i),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o),
        .evt_o   (evt_o)
    );

    // Monitor: compares queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t       it;
                logic [31:0] got;
                it = sbq.pop_front();
                case (it.kind)
                    K_REG:   got = rdata_o;
                    K_IRQ:   got = {31'b0, irq_o};
                    default: got = {31'b0, evt_o};
                endcase
                total++;
                if (got !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got=%h exp=%h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        we_i = 1'b0; wdata_i = '0;
    endtask

    task automatic check_reg(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] e);
        item_t it;
        addr_i = a;
        it.kind = K_REG; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_pin(input string tag, input kind_e k, input logic v);
        item_t it;
        it.kind = k; it.exp = {31'b0, v}; it.tag = tag;
        sbq.push_back(it);
    endtask

    initial begin
        tick(3);
        rst_i = 1'b0;
        tick(1);

        // Reset state
        expect_pin("R1 irq after reset", K_IRQ, 1'b0);
        expect_pin("R1 evt after reset", K_EVT, 1'b0);
        check_reg("R1 rise enable", OFF_RISE_EN, 32'h0);
        check_reg("R1 rise pending", OFF_RISE_PEND, 32'h0);
        check_reg("R1 fall pending", OFF_FALL_PEND, 32'h0);
        check_reg("R1 irq mask", OFF_IRQ_MASK, 32'h0);

        // Configuration and readback
        wr(OFF_RISE_EN, 32'h5);
        wr(OFF_FALL_EN, 32'h6);
        wr(OFF_IRQ_MASK, 32'h1);
        wr(OFF_EVT_MASK, 32'h4);
        check_reg("R2 rise enable readback", OFF_RISE_EN, 32'h5);
        check_reg("R2 fall enable readback", OFF_FALL_EN, 32'h6);
        check_reg("R2 irq mask readback", OFF_IRQ_MASK, 32'h1);
        check_reg("R2 evt mask readback", OFF_EVT_MASK, 32'h4);

        // Line 0 rising edge, rise enabled, event masked
        line_i = 32'h1;
        tick(3);
        expect_pin("R11 no pulse for line without evt mask", K_EVT, 1'b0);
        check_reg("R3 rise pending on third edge", OFF_RISE_PEND, 32'h1);
        expect_pin("R10 irq from unmasked pending", K_IRQ, 1'b1);
        tick(5);
        wr(OFF_RISE_PEND, 32'h1);
        tick(3);
        check_reg("R3 held level does not re-set", OFF_RISE_PEND, 32'h0);
        expect_pin("R10 irq low after clear", K_IRQ, 1'b0);

        // Line 0 falls; no fall enable
        line_i = 32'h0;
        tick(3);
        check_reg("R6 fall on rise-only line ignored", OFF_FALL_PEND, 32'h0);

        // Line 3 with no enables at all
        line_i = 32'h8;
        tick(3);
        expect_pin("R6 no pulse for disabled line", K_EVT, 1'b0);
        check_reg("R6 rise on disabled line ignored", OFF_RISE_PEND, 32'h0);
        line_i = 32'h0;
        tick(3);
        check_reg("R6 fall on disabled line ignored", OFF_FALL_PEND, 32'h0);

        // Line 1: fall only
        line_i = 32'h2;
        tick(3);
        check_reg("R4 rise on fall-only line ignored", OFF_RISE_PEND, 32'h0);
        line_i = 32'h0;
        tick(3);
        check_reg("R4 fall pending set", OFF_FALL_PEND, 32'h2);
        expect_pin("R10 masked pending keeps irq low", K_IRQ, 1'b0);
        wr(OFF_IRQ_MASK, 32'h3);
        expect_pin("R10 irq after unmask", K_IRQ, 1'b1);
        wr(OFF_FALL_PEND, 32'h0);
        check_reg("R7 writing zero keeps pending", OFF_FALL_PEND, 32'h2);
        wr(OFF_FALL_PEND, 32'h2);
        expect_pin("R10 irq low after clear", K_IRQ, 1'b0);
        check_reg("R7 write one clears", OFF_FALL_PEND, 32'h0);

        // Line 2: both edges, event mask set
        line_i = 32'h4;
        tick(3);
        expect_pin("R11 pulse on masked-in edge", K_EVT, 1'b1);
        check_reg("R5 rising edge on both-edge line", OFF_RISE_PEND, 32'h4);
        expect_pin("R11 pulse lasts one cycle", K_EVT, 1'b0);
        line_i = 32'h0;
        tick(3);
        check_reg("R5 falling edge on both-edge line", OFF_FALL_PEND, 32'h4);
        check_reg("R5 rise pending kept", OFF_RISE_PEND, 32'h4);
        wr(OFF_RISE_PEND, 32'h4);
        wr(OFF_FALL_PEND, 32'h4);

        // Software trigger
        wr(OFF_SW_TRIG, 32'h20);
        expect_pin("R11 no pulse for sw trigger on unmasked line", K_EVT, 1'b0);
        check_reg("R9 sw trigger ignores enables", OFF_RISE_PEND, 32'h20);
        check_reg("R9 sw trigger reads zero", OFF_SW_TRIG, 32'h0);
        wr(OFF_RISE_PEND, 32'h20);
        wr(OFF_SW_TRIG, 32'h4);
        expect_pin("R11 pulse for sw trigger", K_EVT, 1'b1);
        check_reg("R9 sw trigger sets rise pending", OFF_RISE_PEND, 32'h4);

        // Edge collides with write-one clear on the same clock edge
        line_i = 32'h4;
        tick(2);
        wr(OFF_RISE_PEND, 32'h4);
        check_reg("R8 set wins over clear", OFF_RISE_PEND, 32'h4);
        line_i = 32'h0;
        tick(3);
        check_reg("R5 fall after collision", OFF_FALL_PEND, 32'h4);

        check_reg("R12 unmapped address reads zero", 8'h40, 32'h0);

        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule